// File: doc/BRIEF.md
# Pause Flow Control Resolver

This block settles which Ethernet pause directions a port uses once link bring-up has finished. A start pulse begins a resolution. The block samples the auto-negotiation complete status bit twice, because that bit is latched, and uses only the second sample. It then combines the local and link-partner pause and asymmetric-direction bits, the requested mode, a strict-standard flag and the duplex into a 2-bit mode. The mode is held in a register and announced with a one-cycle done strobe.

The resolution departs from the strict standard in two places. When the partner advertises nothing useful, the block falls back to receive-only pause. When both ends advertise symmetric pause but only receive pause was requested, it turns full into receive-only. When the link was forced because auto-negotiation failed, the requested mode is applied directly and the status bit is not consulted.

Top module: `pause_fc_resolver`

## Requirements
- R1: After reset, mode_o is 0 and done_o is 0.
- R2: The mode encoding is 0 = none, 1 = receive pause only, 2 = transmit pause only, 3 = full. A start_i pulse sampled at clock edge k makes the block sample an_status_i at edges k+1 and k+2. mode_o and done_o update at edge k+3, and done_o is high for exactly one cycle.
- R3: With local pause and partner pause both set, the result is 3 when the requested mode is full (or default), and 1 otherwise. Both asymmetric bits are ignored in this case.
- R4: Local pause 0 with local asym 1, and partner pause 1 with partner asym 1, resolves to 2.
- R5: Local pause 1 with local asym 1, and partner pause 0 with partner asym 1, resolves to 1.
- R6: Every other bit combination resolves to 0 when the requested mode is 0 or 2, or when strict_i is 1. Otherwise it resolves to 1.
- R7: On the negotiated path, full_duplex_i = 0 forces the result to 0 whatever the table gives.
- R8: With an_failed_i = 1, mode_o takes the requested mode directly. The table, duplex and an_status_i are all ignored, and a default request gives 3.
- R9: Only the second status sample counts. If it is 0 on the negotiated path, done_o still pulses but mode_o keeps its previous value.
- R10: A start_i pulse that arrives while a resolution is in progress is ignored: it produces no extra done_o pulse.
- R11: req_mode_i is 3 bits wide. Codes 0 to 3 follow the R2 encoding, and any code with bit 2 set means default, which is treated as full (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle request to resolve |
| loc_pause_i | input | 1 | Local symmetric pause advertisement |
| loc_asym_i | input | 1 | Local asymmetric direction advertisement |
| lp_pause_i | input | 1 | Partner symmetric pause ability |
| lp_asym_i | input | 1 | Partner asymmetric direction ability |
| req_mode_i | input | 3 | Requested mode, bit 2 set means default |
| strict_i | input | 1 | Strict standard resolution, no fallback |
| full_duplex_i | input | 1 | 1 when the link is full duplex |
| an_status_i | input | 1 | Latched auto-negotiation complete status |
| an_failed_i | input | 1 | Link was forced after auto-negotiation failed |
| mode_o | output | 2 | Resolved pause mode |
| done_o | output | 1 | One-cycle strobe when a resolution ends |

## Verification
Several rules can meet in one resolution, and the bench sets them up together on purpose. A forced link can coincide with half duplex and a cleared status bit, and the forced request must win over both. A half-duplex link can coincide with a table row that would give full, and the override must win. A second start can arrive during the sampling window; the bench checks that it leaves exactly one done pulse. Random runs mix all inputs freely, and every outcome is compared with a bench model of the rules.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int MODE_W = 2;
  localparam int REQ_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    FC_NONE = 2'd0,
    FC_RX   = 2'd1,
    FC_TX   = 2'd2,
    FC_FULL = 2'd3
  } fc_mode_e;

  // bit 2 of the request selects default, which means full
  function automatic fc_mode_e norm_req(input logic [REQ_W-1:0] req);
    if (req[REQ_W-1]) return FC_FULL;
    return fc_mode_e'(req[MODE_W-1:0]);
  endfunction
endpackage

// File: rtl/pfc_seq.sv
module pfc_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic an_status_i,
  output logic an_ok_o,
  output logic apply_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_SMP1, ST_SMP2, ST_APPLY} st_e;
  st_e st_q, st_d;
  logic an_ok_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_SMP1;
      ST_SMP1:  st_d = ST_SMP2;   // first read clears the latch, value dropped
      ST_SMP2:  st_d = ST_APPLY;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      an_ok_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_SMP2) an_ok_q <= an_status_i;
    end
  end

  assign an_ok_o = an_ok_q;
  assign apply_o = (st_q == ST_APPLY);

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SMP2) |=> (st_q == ST_APPLY)); // R10
  AST_SAMPLE_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_APPLY) |-> (an_ok_q == $past(an_status_i))); // R9
endmodule

// File: rtl/pfc_resolve.sv
module pfc_resolve
  import pfc_pkg::*;
(
  input  logic             loc_pause_i,
  input  logic             loc_asym_i,
  input  logic             lp_pause_i,
  input  logic             lp_asym_i,
  input  logic [REQ_W-1:0] req_mode_i,
  input  logic             strict_i,
  input  logic             full_duplex_i,
  output fc_mode_e         mode_o
);
  fc_mode_e req, tbl;

  always_comb begin
    req = norm_req(req_mode_i);
    if (loc_pause_i && lp_pause_i)
      tbl = (req == FC_FULL) ? FC_FULL : FC_RX;
    else if (!loc_pause_i && loc_asym_i && lp_pause_i && lp_asym_i)
      tbl = FC_TX;
    else if (loc_pause_i && loc_asym_i && !lp_pause_i && lp_asym_i)
      tbl = FC_RX;
    else if (req == FC_NONE || req == FC_TX || strict_i)
      tbl = FC_NONE;
    else
      tbl = FC_RX;   // fallback for partners that advertise nothing
    mode_o = full_duplex_i ? tbl : FC_NONE;
  end
endmodule

// File: rtl/pause_fc_resolver.sv
module pause_fc_resolver
  import pfc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             loc_pause_i,
  input  logic             loc_asym_i,
  input  logic             lp_pause_i,
  input  logic             lp_asym_i,
  input  logic [REQ_W-1:0] req_mode_i,
  input  logic             strict_i,
  input  logic             full_duplex_i,
  input  logic             an_status_i,
  input  logic             an_failed_i,
  output logic [MODE_W-1:0] mode_o,
  output logic             done_o
);
  logic     an_ok, apply;
  fc_mode_e neg_mode;
  fc_mode_e mode_q;
  logic     done_q;

  pfc_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .an_status_i (an_status_i),
    .an_ok_o     (an_ok),
    .apply_o     (apply)
  );

  pfc_resolve u_res (
    .loc_pause_i   (loc_pause_i),
    .loc_asym_i    (loc_asym_i),
    .lp_pause_i    (lp_pause_i),
    .lp_asym_i     (lp_asym_i),
    .req_mode_i    (req_mode_i),
    .strict_i      (strict_i),
    .full_duplex_i (full_duplex_i),
    .mode_o        (neg_mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= FC_NONE;
      done_q <= 1'b0;
    end else begin
      done_q <= apply;
      if (apply) begin
        if (an_failed_i)  mode_q <= norm_req(req_mode_i);
        else if (an_ok)   mode_q <= neg_mode;
      end
    end
  end

  assign mode_o = mode_q;
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_MODE_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> done_o); // R2
  AST_HALF_DUPLEX_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(an_failed_i) && $past(an_ok) && !$past(full_duplex_i))
      |-> (mode_o == 2'd0)); // R7
  AST_KEEP_ON_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(an_failed_i) && !$past(an_ok)) |-> $stable(mode_o)); // R9
  AST_FORCED_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(an_failed_i) && $past(req_mode_i[2])) |-> (mode_o == 2'd3)); // R8
endmodule

// File: tb/pause_fc_resolver_test.sv
module pause_fc_resolver_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, lpa = 0, laa = 0, ppa = 0, paa = 0, strict = 0, fd = 1, an_st = 0, an_f = 0;
  logic [2:0] req = 0;
  logic [1:0] mode;
  logic done;
  int errors = 0, checks = 0;
  logic [1:0] model = 0;

  always #4 clk = ~clk;

  pause_fc_resolver uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .loc_pause_i(lpa), .loc_asym_i(laa), .lp_pause_i(ppa), .lp_asym_i(paa),
    .req_mode_i(req), .strict_i(strict), .full_duplex_i(fd),
    .an_status_i(an_st), .an_failed_i(an_f), .mode_o(mode), .done_o(done)
  );

  function automatic logic [1:0] exp_mode(logic [1:0] prev, logic s2);
    logic [1:0] r;
    logic [1:0] t;
    r = req[2] ? 2'd3 : req[1:0];
    if (an_f) return r;
    if (!s2) return prev;
    if (lpa && ppa) t = (r == 2'd3) ? 2'd3 : 2'd1;
    else if (!lpa && laa && ppa && paa) t = 2'd2;
    else if (lpa && laa && !ppa && paa) t = 2'd1;
    else if (r == 2'd0 || r == 2'd2 || strict) t = 2'd0;
    else t = 2'd1;
    return fd ? t : 2'd0;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string rq);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // one resolution; restart=1 pulses start again during sampling
  task automatic resolve(logic s1, logic s2, bit restart, string rq);
    logic [1:0] e;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0; an_st = s1;
    @(negedge clk) an_st = s2; start = restart;
    @(negedge clk) start = 0;
    chk(done, 0, "R2");
    e = exp_mode(model, s2);
    @(negedge clk);
    chk(done, 1, "R2");
    chk(mode, e, rq);
    model = e;
    @(negedge clk);
    chk(done, 0, restart ? "R10" : "R2");
    @(negedge clk);
    chk(done, 0, restart ? "R10" : "R2");
  endtask

  task automatic setin(logic a, logic b, logic c, logic d, logic [2:0] rm,
                       logic st, logic dup, logic f);
    lpa = a; laa = b; ppa = c; paa = d; req = rm; strict = st; fd = dup; an_f = f;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    #1;
    chk(mode, 0, "R1"); chk(done, 0, "R1");
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(mode, 0, "R1"); chk(done, 0, "R1");
    setin(1,0,1,0,3'd3,0,1,0); resolve(0,1,0,"R3");
    setin(1,1,1,1,3'd1,0,1,0); resolve(0,1,0,"R3");
    setin(1,0,1,1,3'd4,0,1,0); resolve(0,1,0,"R11");
    setin(0,1,1,1,3'd3,0,1,0); resolve(0,1,0,"R4");
    setin(1,1,0,1,3'd3,0,1,0); resolve(0,1,0,"R5");
    setin(0,0,0,0,3'd0,0,1,0); resolve(0,1,0,"R6");
    setin(1,0,0,0,3'd3,0,1,0); resolve(0,1,0,"R6");
    setin(1,0,0,0,3'd3,1,1,0); resolve(0,1,0,"R6");
    setin(0,0,0,0,3'd2,0,1,0); resolve(0,1,0,"R6");
    setin(1,1,1,1,3'd3,0,0,0); resolve(0,1,0,"R7");
    setin(1,1,1,1,3'd3,0,1,0); resolve(1,0,0,"R9");
    setin(0,0,0,0,3'd2,0,0,1); resolve(0,0,0,"R8");
    setin(0,0,0,0,3'd6,1,0,1); resolve(1,0,0,"R8");
    setin(0,1,1,1,3'd3,0,1,0); resolve(0,1,1,"R10");
    for (int i = 0; i < 300; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      setin(r[0], r[1], r[2], r[3], r[6:4], r[7], r[8], ($urandom % 5) == 0);
      resolve(1'($urandom), ($urandom % 4) != 0, r[9] & r[0], "R6");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule